// File: doc/BRIEF.md
# Sticky Status and Alert Latch

This block holds the eight-bit read-only status word of a multi-channel temperature monitor and drives two active-low pins: an interrupt-style alert and an over-temperature shutdown line. Limit comparators, the converter and a diode-fault detector feed it one flag per condition every clock. The bus interface pulses a read strobe when the host fetches the status byte, and a second strobe when an alert-response-address cycle completes.

Five of the bits are sticky, so a brief excursion past a limit is still visible at the next read. A read clears each sticky bit only if its condition has gone away. The alert pin asserts when any sticky bit sets. It stays low until the host finishes an alert-response cycle at a time when every sticky bit is already clear. The busy bit and the two shutdown-limit bits follow their inputs. The shutdown pin is low while either shutdown-limit bit is high.

Top module: `status_alert_latch`

## Requirements
- R1: While `rst` is high at a clock edge, `status_o` becomes 0 and both `alert_n_o` and `therm_n_o` become 1.
- R2: Bit positions in `status_o`: 7 busy, 6 internal above high limit, 5 internal below low limit, 4 remote above high limit, 3 remote below low limit, 2 open diode, 1 remote above shutdown limit, 0 internal above shutdown limit.
- R3: A sticky bit (6 to 2) reads 1 from the clock edge after any cycle in which its condition input is high. It keeps that value through cycles without a read strobe.
- R4: On a clock edge where `rd_stb_i` is high, each sticky bit takes the value its condition input has in that cycle. A bit whose condition is still high stays set, because setting wins over clearing.
- R5: Bits 7, 1 and 0 equal their inputs from the previous cycle. `rd_stb_i` has no effect on them.
- R6: `therm_n_o` is 0 exactly when bit 1 or bit 0 of `status_o` is 1.
- R7: `alert_n_o` goes to 0 on the edge at which any sticky bit changes from 0 to 1.
- R8: Once low, `alert_n_o` stays low through every cycle in which `ara_done_i` is low.
- R9: An edge with `ara_done_i` high sets `alert_n_o` to 1 only if all sticky bits are 0 in that cycle and no sticky bit sets on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busy_i | input | 1 | Converter busy |
| int_hi_i | input | 1 | Internal channel above high limit |
| int_lo_i | input | 1 | Internal channel below low limit |
| rem_hi_i | input | 1 | Remote channel above high limit |
| rem_lo_i | input | 1 | Remote channel below low limit |
| open_i | input | 1 | Open circuit on a remote diode input |
| rem_therm_i | input | 1 | Remote channel above shutdown limit |
| int_therm_i | input | 1 | Internal channel above shutdown limit |
| rd_stb_i | input | 1 | Status byte read strobe |
| ara_done_i | input | 1 | Alert-response-address cycle completed |
| status_o | output | 8 | Status word |
| alert_n_o | output | 1 | Alert pin, active low |
| therm_n_o | output | 1 | Shutdown pin, active low |

## Verification
A dense pseudo-random sweep sets about half the condition flags each cycle and mixes in reads and response strobes. It shows whether a read clears only the bits whose conditions have fallen, and whether the live bits ignore reads. A sparse sweep pulses a single condition now and then, so the sticky word empties often. This tells a correct alert release apart from one that ignores the sticky bits or a same-cycle set. Directed sequences pin down the field positions, set-over-clear during a read, and an alert held across strobes that arrive too early.

// File: rtl/status_alert_latch.sv
module status_alert_latch (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy_i,
  input  logic       int_hi_i,
  input  logic       int_lo_i,
  input  logic       rem_hi_i,
  input  logic       rem_lo_i,
  input  logic       open_i,
  input  logic       rem_therm_i,
  input  logic       int_therm_i,
  input  logic       rd_stb_i,
  input  logic       ara_done_i,
  output logic [7:0] status_o,
  output logic       alert_n_o,
  output logic       therm_n_o
);

  logic [4:0] cond, sticky_q, sticky_d;
  logic [2:0] live_q;
  logic       alert_q, therm_q, rise;

  assign cond     = {int_hi_i, int_lo_i, rem_hi_i, rem_lo_i, open_i};
  assign sticky_d = rd_stb_i ? cond : (sticky_q | cond);
  assign rise     = |(sticky_d & ~sticky_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= '0;
      live_q   <= '0;
      alert_q  <= 1'b0;
      therm_q  <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      live_q   <= {busy_i, rem_therm_i, int_therm_i};
      therm_q  <= rem_therm_i | int_therm_i;
      if (rise)
        alert_q <= 1'b1;
      else if (ara_done_i && sticky_q == '0)
        alert_q <= 1'b0;
    end
  end

  assign status_o  = {live_q[2], sticky_q, live_q[1:0]};
  assign alert_n_o = ~alert_q;
  assign therm_n_o = ~therm_q;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (status_o == 8'h00 && alert_n_o && therm_n_o));

  assert_sticky_set_R3: assert property (@(posedge clk) disable iff (rst)
    int_hi_i |=> status_o[6]);

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (status_o[2] && !rd_stb_i) |=> status_o[2]);

  assert_read_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && !rem_lo_i) |=> !status_o[3]);

  assert_therm_pin_R6: assert property (@(posedge clk) disable iff (rst)
    (rem_therm_i || int_therm_i) |=> !therm_n_o);

  assert_alert_rise_R7: assert property (@(posedge clk) disable iff (rst)
    (!status_o[5] && int_lo_i) |=> !alert_n_o);

  assert_alert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!alert_n_o && !ara_done_i) |=> !alert_n_o);

  assert_alert_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (!alert_n_o && (|status_o[6:2])) |=> !alert_n_o);

endmodule

// File: tb/status_alert_latch_test.sv
module status_alert_latch_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busy_i = 0, int_hi_i = 0, int_lo_i = 0, rem_hi_i = 0, rem_lo_i = 0;
  logic open_i = 0, rem_therm_i = 0, int_therm_i = 0, rd_stb_i = 0, ara_done_i = 0;
  logic [7:0] status_o;
  logic alert_n_o, therm_n_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [4:0] m_sticky;
  logic [2:0] m_live;
  logic       m_alert;

  always #10 clk = ~clk;

  status_alert_latch uut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(logic [7:0] p, logic rd, logic ara);
    {busy_i, int_hi_i, int_lo_i, rem_hi_i, rem_lo_i, open_i, rem_therm_i, int_therm_i} = p;
    rd_stb_i = rd;
    ara_done_i = ara;
  endtask

  task automatic step(logic [7:0] p, logic rd, logic ara);
    logic [4:0] c, nxt;
    drive(p, rd, ara);
    c   = p[6:2];
    nxt = rd ? c : (m_sticky | c);
    if (|(nxt & ~m_sticky)) m_alert = 1'b1;
    else if (ara && m_sticky == 5'd0) m_alert = 1'b0;
    m_sticky = nxt;
    m_live = {p[7], p[1], p[0]};
    @(negedge clk);
  endtask

  task automatic compare();
    chk("R4", {3'b0, status_o[6:2]}, {3'b0, m_sticky});
    chk("R5", {5'b0, status_o[7], status_o[1:0]}, {5'b0, m_live});
    chk("R6", {7'b0, therm_n_o}, {7'b0, ~(m_live[1] | m_live[0])});
    chk("R9", {7'b0, alert_n_o}, {7'b0, ~m_alert});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    drive(8'hFF, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R1", status_o, 8'h00);
    chk("R1", {6'b0, alert_n_o, therm_n_o}, 8'h03);
    rst = 1'b0;
    m_sticky = 0; m_live = 0; m_alert = 0;

    // R2 field positions, one condition at a time, cleared by a read afterwards
    for (int b = 0; b < 8; b++) begin
      step(8'h01 << b, 1'b0, 1'b0);
      chk("R2", status_o, 8'h01 << b);
      step(8'h00, 1'b1, 1'b0);
      step(8'h00, 1'b0, 1'b1);
    end
    compare();

    // R3 sticky across idle cycles, R7 alert on set, R8 held without response
    step(8'h10, 1'b0, 1'b0);
    chk("R7", {7'b0, alert_n_o}, 8'h00);
    for (int k = 0; k < 4; k++) step(8'h00, 1'b0, 1'b0);
    chk("R3", status_o, 8'h10);
    chk("R8", {7'b0, alert_n_o}, 8'h00);
    step(8'h00, 1'b0, 1'b1);
    chk("R9", {7'b0, alert_n_o}, 8'h00);
    step(8'h10, 1'b1, 1'b0);
    chk("R4", status_o, 8'h10);
    step(8'h00, 1'b1, 1'b0);
    chk("R4", status_o, 8'h00);
    chk("R8", {7'b0, alert_n_o}, 8'h00);
    step(8'h00, 1'b0, 1'b1);
    chk("R9", {7'b0, alert_n_o}, 8'h01);
    step(8'h83, 1'b1, 1'b0);
    chk("R5", status_o, 8'h83);
    chk("R6", {7'b0, therm_n_o}, 8'h00);

    for (int i = 0; i < 2048; i++) begin
      step(8'((i * 73 + 11) ^ (i >> 2)), (i % 5) == 0, (i % 7) == 3);
      compare();
    end
    for (int i = 0; i < 2048; i++) begin
      step((i % 9 == 0) ? 8'(8'h01 << (i % 8)) : 8'h00, (i % 4) == 1, (i % 3) == 0);
      compare();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule